// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side master that reads results from a 24-bit serial converter running in external-clock mode. When `start_i` is pulsed it drives the active-low select line low. It then watches the serial data line, which carries a live busy flag while a conversion is in progress. Once the line drops low, the block generates 32 serial clock pulses and captures one frame bit at each rising edge.

At the end of the frame the select line is released and the captured fields are presented in parallel, together with a one-cycle valid strobe. The fields are the channel bit, the sign flag, the extended-range flag, the 24-bit offset-style code and the four fine bits below the code. The block also combines the sign flag, the range flag and the code into one two's-complement value. That value spans from -1/8 to 9/8 of the reference, in units of one code step.

If the busy flag never clears within a parameterised window, the transfer is abandoned and an error flag is raised. The serial clock half-period is a parameter counted in system clocks.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `sel_n_o` is 1, `ser_clk_o` is 0, `valid_o` is 0 and `timeout_o` is 0.
- R2: A `start_i` pulse in the idle state drives `sel_n_o` low. No rising edge appears on `ser_clk_o` while `ser_din_i` is still high (converter busy), and `ser_clk_o` stays low whenever `sel_n_o` is high.
- R3: Once `ser_din_i` is seen low, exactly 32 rising edges are produced on `ser_clk_o`. `ser_din_i` is captured at each rising edge, and the frame is numbered so that the first captured bit is bit 31 (the busy flag) and the last is bit 0.
- R4: Each high phase and each low phase of `ser_clk_o` inside a frame lasts at least `HALF_CYC` system clocks.
- R5: After the 32nd falling edge, `sel_n_o` returns high and `valid_o` pulses for exactly one cycle. In the same cycle the outputs carry these frame fields: `chan_o` = bit 30, `sign_o` = bit 29, `xrange_o` = bit 28, `code_o` = bits 27..4 (most significant first) and `fine_o` = bits 3..0.
- R6: `result_o` is a 26-bit two's-complement value, formed from the sign flag, the range flag and the code. If sign=1 and range=1 it is code + 2^24. If sign=0 and range=1 it is code - 2^24. In the other two cases it is the code itself. For example, sign=0, range=1, code=0xFFFFFF gives -1, and sign=1, range=1, code=0x1FFFFF gives 0x11FFFFF.
- R7: The block first waits a settle time of `HALF_CYC` clocks. If `ser_din_i` then stays high for `TIMEOUT_CYC` further clocks, `sel_n_o` goes high without any clock pulse and `timeout_o` goes to 1 with no `valid_o`. `timeout_o` stays at 1 until the next accepted `start_i`, which clears it.
- R8: A `start_i` pulse while a transfer is active is ignored. The frame in progress completes with 32 pulses and a single `valid_o`, and no new transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one frame read |
| ser_din_i | input | 1 | Serial data from converter (busy flag, then frame) |
| sel_n_o | output | 1 | Active-low converter select |
| ser_clk_o | output | 1 | Serial clock to converter |
| valid_o | output | 1 | One-cycle strobe: new fields available |
| chan_o | output | 1 | Channel bit of the frame |
| sign_o | output | 1 | Sign flag (1 = positive) |
| xrange_o | output | 1 | Input outside the normal range |
| code_o | output | 24 | Offset-style conversion code |
| fine_o | output | 4 | Fine bits below the code |
| result_o | output | 26 | Signed extended-range result |
| timeout_o | output | 1 | Busy flag never cleared |

## Verification
The hardest situations to reach from the ports are a busy flag that clears just inside the timeout window and one that never clears. A converter model in the bench holds its data line high for a programmed number of clocks after select falls. That number is set just below the limit to get a completed frame, and far above it to force the abort. The clamp points and the zero and -1 codes, which exercise each branch of the signed reassembly, are driven as directed frames between randomly generated ones. A start request is also injected mid-frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int CODE_W  = 24;
  localparam int FINE_W  = 4;
  localparam int FRAME_W = 4 + CODE_W + FINE_W;
  localparam int RES_W   = CODE_W + 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_POLL,
    ST_SHIFT
  } rd_state_e;

  // frame after the leading busy bit has been dropped
  typedef struct packed {
    logic              chan;
    logic              sign;
    logic              xrange;
    logic [CODE_W-1:0] code;
    logic [FINE_W-1:0] fine;
  } payload_t;
endpackage

// File: rtl/sck_gen.sv
module sck_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          term;

  assign term = (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = run_i && term && !sck_q;
  assign fall_o = run_i && term && sck_q;

  // R4: a level change only follows a full phase of HALF_CYC counts
  p_phase_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> (cnt_q == '0));
endmodule

// File: rtl/frame_shift.sv
module frame_shift #(
  parameter int FRAME_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic                             shift_i,
  input  logic                             bit_i,
  output logic [FRAME_W-2:0]               data_o,
  output logic [$clog2(FRAME_W+1)-1:0]     count_o
);
  localparam int NW = $clog2(FRAME_W + 1);

  logic [FRAME_W-2:0] data_q;
  logic [NW-1:0]      cnt_q;

  // leading busy bit falls off the top after all bits are in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (shift_i) begin
      data_q <= {data_q[FRAME_W-3:0], bit_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign data_o  = data_q;
  assign count_o = cnt_q;

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(FRAME_W));
endmodule

// File: rtl/field_decode.sv
module field_decode
  import adc_rd_pkg::*;
(
  input  payload_t                 pay_i,
  output logic signed [RES_W-1:0]  result_o
);
  always_comb begin
    unique case ({pay_i.sign, pay_i.xrange})
      2'b11:   result_o = {2'b01, pay_i.code};  // above reference
      2'b01:   result_o = {2'b11, pay_i.code};  // below zero
      default: result_o = {2'b00, pay_i.code};
    endcase
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     ser_din_i,
  output logic                     sel_n_o,
  output logic                     ser_clk_o,
  output logic                     valid_o,
  output logic                     chan_o,
  output logic                     sign_o,
  output logic                     xrange_o,
  output logic [CODE_W-1:0]        code_o,
  output logic [FINE_W-1:0]        fine_o,
  output logic signed [RES_W-1:0]  result_o,
  output logic                     timeout_o
);
  localparam int SW = $clog2(HALF_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int NW = $clog2(FRAME_W + 1);

  rd_state_e state_q;
  logic [SW-1:0] set_q;
  logic [TW-1:0] tmo_cnt_q;
  logic sel_n_q, valid_q, tmo_q;
  logic sck_run, sck_rise, sck_fall, last_fall;
  logic [FRAME_W-2:0] shreg;
  logic [NW-1:0] nbits;
  payload_t pay, pay_q;
  logic signed [RES_W-1:0] res_d, res_q;

  assign sck_run = (state_q == ST_SHIFT);

  sck_gen #(.HALF_CYC(HALF_CYC)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sck_run),
    .sck_o  (ser_clk_o),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_POLL),
    .shift_i (sck_rise),
    .bit_i   (ser_din_i),
    .data_o  (shreg),
    .count_o (nbits)
  );

  assign pay = payload_t'(shreg);

  field_decode u_dec (
    .pay_i    (pay),
    .result_o (res_d)
  );

  assign last_fall = sck_fall && (nbits == NW'(FRAME_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      set_q     <= '0;
      tmo_cnt_q <= '0;
      sel_n_q   <= 1'b1;
      valid_q   <= 1'b0;
      tmo_q     <= 1'b0;
      pay_q     <= '0;
      res_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETTLE;
          sel_n_q <= 1'b0;
          tmo_q   <= 1'b0;
          set_q   <= '0;
        end
        ST_SETTLE: begin
          if (set_q == SW'(HALF_CYC - 1)) begin
            state_q   <= ST_POLL;
            tmo_cnt_q <= '0;
          end else begin
            set_q <= set_q + 1'b1;
          end
        end
        ST_POLL: begin
          if (!ser_din_i) begin
            state_q <= ST_SHIFT;
          end else if (tmo_cnt_q == TW'(TIMEOUT_CYC - 1)) begin
            state_q <= ST_IDLE;
            sel_n_q <= 1'b1;
            tmo_q   <= 1'b1;
          end else begin
            tmo_cnt_q <= tmo_cnt_q + 1'b1;
          end
        end
        ST_SHIFT: if (last_fall) begin
          state_q <= ST_IDLE;
          sel_n_q <= 1'b1;
          valid_q <= 1'b1;
          pay_q   <= pay;
          res_q   <= res_d;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_n_o   = sel_n_q;
  assign valid_o   = valid_q;
  assign timeout_o = tmo_q;
  assign chan_o    = pay_q.chan;
  assign sign_o    = pay_q.sign;
  assign xrange_o  = pay_q.xrange;
  assign code_o    = pay_q.code;
  assign fine_o    = pay_q.fine;
  assign result_o  = res_q;

  p_clk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_o |-> !ser_clk_o);

  p_no_clk_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE || state_q == ST_POLL) |-> !ser_clk_o);

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sel_n_o);

  p_tmo_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (sel_n_o && !valid_o && !ser_clk_o));

  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !last_fall) |=> (state_q == ST_SHIFT));
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int DIV = 2;
  localparam int TMO = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdo = 1'b1;
  logic sel_n, sclk, valid, chan, sign, xr, tmo;
  logic [23:0] code;
  logic [3:0]  fine;
  logic signed [25:0] result;

  always #5 clk = ~clk;

  adc_frame_reader #(.HALF_CYC(DIV), .TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ser_din_i(sdo),
    .sel_n_o(sel_n), .ser_clk_o(sclk), .valid_o(valid), .chan_o(chan),
    .sign_o(sign), .xrange_o(xr), .code_o(code), .fine_o(fine),
    .result_o(result), .timeout_o(tmo)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // converter model
  logic [31:0] sl_frame = '0;
  int sl_delay = 0;
  int busy_left = 0;
  int bitptr = 31;
  logic sck_prev = 1'b0;
  int rise_cnt = 0, early_rise = 0, phase_err = 0, lvl_len = 0, valid_cnt = 0;

  always @(negedge clk) begin
    if (sel_n) begin
      bitptr = 31;
      busy_left = sl_delay;
      lvl_len = 0;
    end else begin
      if (sclk && !sck_prev) begin
        rise_cnt++;
        if (busy_left > 0) early_rise++;
      end
      if (sclk != sck_prev) begin
        if (lvl_len < DIV) phase_err++;
        lvl_len = 1;
      end else lvl_len++;
      if (sck_prev && !sclk) bitptr--;
      if (busy_left > 0) busy_left--;
    end
    if (sel_n || busy_left > 0 || bitptr < 0) sdo = 1'b1;
    else sdo = sl_frame[bitptr];
    if (valid) valid_cnt++;
    sck_prev = sclk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_res(input logic s, input logic x, input logic [23:0] c);
    if (s && x) return longint'(c) + 64'sd16777216;
    if (!s && x) return longint'(c) - 64'sd16777216;
    return longint'(c);
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_mon();
    rise_cnt = 0; early_rise = 0; phase_err = 0; valid_cnt = 0;
  endtask

  task automatic run_frame(input logic c, input logic s, input logic x,
                           input logic [23:0] cd, input logic [3:0] f, input int dly,
                           input bit mid_start);
    bit got;
    sl_frame = {1'b0, c, s, x, cd, f};
    sl_delay = dly;
    clear_mon();
    pulse_start();
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (mid_start && i == 40) start = 1'b1;
      else start = 1'b0;
      if (valid) got = 1;
    end
    chk(got, "R5 valid seen", longint'(got), 1);
    chk(sel_n, "R5 select released", longint'(sel_n), 1);
    chk(chan == c, "R5 chan", longint'(chan), longint'(c));
    chk(sign == s, "R5 sign", longint'(sign), longint'(s));
    chk(xr == x, "R5 range", longint'(xr), longint'(x));
    chk(code == cd, "R3 code order", longint'(code), longint'(cd));
    chk(fine == f, "R5 fine", longint'(fine), longint'(f));
    chk(longint'(result) == exp_res(s, x, cd), "R6 result", longint'(result), exp_res(s, x, cd));
    chk(tmo == 1'b0, "R7 no timeout", longint'(tmo), 0);
    repeat (3 * DIV + 8) @(negedge clk);
    chk(rise_cnt == 32, "R3 rising edges", rise_cnt, 32);
    chk(early_rise == 0, "R2 clock while busy", early_rise, 0);
    chk(phase_err == 0, "R4 short phase", phase_err, 0);
    chk(valid_cnt == 1, mid_start ? "R8 single valid" : "R5 single valid", valid_cnt, 1);
    chk(sel_n, "R8 no new transfer", longint'(sel_n), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(sel_n == 1'b1, "R1 select", longint'(sel_n), 1);
    chk(sclk == 1'b0, "R1 clock", longint'(sclk), 0);
    chk(valid == 1'b0, "R1 valid", longint'(valid), 0);
    chk(tmo == 1'b0, "R1 timeout", longint'(tmo), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners of R6
    run_frame(1'b0, 1'b0, 1'b0, 24'h000000, 4'h3, 10, 0);   // zero code
    run_frame(1'b1, 1'b1, 1'b0, 24'hFFFFFF, 4'hF, 5, 0);    // full scale
    run_frame(1'b0, 1'b1, 1'b1, 24'h1FFFFF, 4'hA, 0, 0);    // upper clamp
    run_frame(1'b1, 1'b0, 1'b1, 24'hE00000, 4'h0, 30, 0);   // lower clamp
    run_frame(1'b0, 1'b0, 1'b1, 24'hFFFFFF, 4'h5, 8, 0);    // -1 step
    run_frame(1'b1, 1'b1, 1'b0, 24'hA5C3_96, 4'h9, TMO - 5, 0); // R7 near limit
    run_frame(1'b0, 1'b1, 1'b0, 24'h5A3C69, 4'h6, 12, 1);   // R8 mid-frame start

    // R7 timeout
    sl_delay = TMO + DIV + 40;
    clear_mon();
    pulse_start();
    repeat (TMO + DIV + 10) @(negedge clk);
    chk(tmo == 1'b1, "R7 timeout flag", longint'(tmo), 1);
    chk(sel_n == 1'b1, "R7 select released", longint'(sel_n), 1);
    repeat (20) @(negedge clk);
    chk(tmo == 1'b1, "R7 flag held", longint'(tmo), 1);
    chk(rise_cnt == 0, "R7 no clocks", rise_cnt, 0);
    chk(valid_cnt == 0, "R7 no valid", valid_cnt, 0);
    run_frame(1'b1, 1'b1, 1'b0, 24'h123456, 4'hC, 4, 0);   // clears flag

    for (int n = 0; n < 30; n++) begin
      int kind;
      logic s, x;
      logic [23:0] cd;
      kind = int'($urandom_range(0, 2));
      cd = 24'($urandom);
      if (kind == 0) begin s = 1'b1; x = 1'b0; end
      else if (kind == 1) begin s = 1'b1; x = 1'b1; cd = {3'b000, cd[20:0]}; end
      else begin s = 1'b0; x = 1'b1; cd = {3'b111, cd[20:0]}; end
      run_frame(1'($urandom), s, x, cd, 4'($urandom), int'($urandom_range(0, 60)), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule